// File: doc/BRIEF.md
# Bus Timeout Catch Monitor

This host-side monitor watches an asynchronous parallel bus, modelled as synchronized logic-level signals. It counts how long address strobe stays active without a data acknowledge from any slave. When the stall reaches a programmable limit, the monitor ends the cycle itself by driving its own acknowledge, so the host never sees a bus error. In the same cycle it stores a snapshot of the faulting access and raises an interrupt request on a programmable level.

Software reads the snapshot through a 32-bit register and programs the monitor by writing the same register. After a fault the monitor locks. It ignores further stalls until the host has acknowledged its interrupt, which returns an 8-bit vector, and has read the snapshot, which empties it. Once both have happened, the monitor is armed again.

Top module: `busCatch`

## Requirements
- R1: After reset, dtackOut, irqOut and vecValid are low and cfgRdata reads zero. The interrupt level is 1, the vector is 8'h0F, the timeout field is 0, and the monitor is armed.
- R2: While armed, a fault is declared at the clock edge that completes N consecutive edges sampling asActive=1 and dtackIn=0, with N = limit*CLK_PER_US. The limit is the timeout field, or DEFAULT_US when the field is 0. Any edge without a stall restarts the count.
- R3: dtackOut rises in the cycle after the fault edge and stays high until an edge samples asActive=0; it then falls in the following cycle.
- R4: The snapshot taken on a fault reads on cfgRdata as: [5:0] address modifier, [7:6] zero, [15:8] extended modifier, [23:16] addrHi[15:8] (address bits 31..24) when addr32=1 or addrHi[7:0] (address bits 23..16) when addr32=0, and [31:24] zero.
- R5: A cfgRdEn pulse while a snapshot is held leaves it readable in that cycle and makes cfgRdata zero from the next cycle.
- R6: While a fault is pending, exactly irqOut[L-1] is high for level L. A write sets L to the highest set bit among cfgWdata[7:1]; a write with bits 7:1 all zero keeps the level unchanged.
- R7: An edge sampling iackActive=1 with iackLevel equal to a pending level makes vecValid high for one cycle with vecOut equal to the vector, and drops irqOut in that cycle. An acknowledge at any other level has no effect.
- R8: While a fault is pending or a snapshot is unread, stalls are not counted or terminated, and the snapshot is not overwritten.
- R9: The monitor re-arms only once the interrupt has been acknowledged and the snapshot has been read, in either order.
- R10: A write with cfgWrEn stores cfgWdata[15:8] as the vector and cfgWdata[23:16] as the timeout field, both used from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| asActive | input | 1 | Address strobe active on the bus |
| dtackIn | input | 1 | Data acknowledge returned by a slave |
| addrHi | input | 16 | Address bits 31..16 of the current access |
| addr32 | input | 1 | 1 for a 32-bit address access, 0 for 24-bit |
| amIn | input | 6 | Address modifier of the current access |
| xamIn | input | 8 | Extended address modifier |
| dtackOut | output | 1 | Acknowledge driven by the monitor to end a stalled cycle |
| irqOut | output | 7 | Interrupt request, bit i is level i+1 |
| iackActive | input | 1 | Interrupt acknowledge cycle in progress |
| iackLevel | input | 3 | Level being acknowledged |
| vecValid | output | 1 | Vector returned this cycle |
| vecOut | output | 8 | Interrupt vector |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgRdEn | input | 1 | Snapshot read strobe |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Snapshot read data |

## Verification
The lock (R8) is the hardest state to reach from the ports. It needs a full timeout first, and then a second stall long enough to trip the limit had the monitor been armed. The stimulus acknowledges the interrupt but leaves the snapshot unread, stalls past the limit, and confirms that dtackOut stays low and the first snapshot is unchanged. It repeats this with the two release steps in the opposite order, so each half of the re-arm condition (R9) is seen to hold the lock on its own. A stall is also broken by one acknowledge pulse midway, which shows the count restarting (R2).

// File: rtl/busCatchPkg.sv
package busCatchPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // fault edge: load the snapshot
    logic clearCap;  // snapshot read: empty it
    logic ackHit;    // matching interrupt acknowledge
  } catchStrobe_t;

endpackage

// File: rtl/busCatchCtrl.sv
module busCatchCtrl
  import busCatchPkg::*;
#(
  parameter int CLK_PER_US = 125,
  parameter int DEFAULT_US = 8,
  parameter int TMO_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             asActive,
  input  logic             dtackIn,
  input  logic             iackActive,
  input  logic [2:0]       iackLevel,
  input  logic             cfgRdEn,
  input  logic [TMO_W-1:0] tmoVal,
  input  logic [2:0]       curLevel,
  output logic             dtackOut,
  output logic             irqPend,
  output catchStrobe_t     stb
);

  localparam int TICK_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic [TICK_W-1:0] tickCnt;
  logic [TMO_W-1:0]  usCnt;
  logic [TMO_W-1:0]  limitM1;
  logic              capValid;
  logic              armed;
  logic              stalled;
  logic              tickLast;
  logic              faultNow;

  assign armed    = !irqPend && !capValid;
  assign stalled  = asActive && !dtackIn && armed && !dtackOut;
  assign limitM1  = ((tmoVal == '0) ? TMO_W'(DEFAULT_US) : tmoVal) - TMO_W'(1);
  assign tickLast = (tickCnt == TICK_W'(CLK_PER_US - 1));
  assign faultNow = stalled && tickLast && (usCnt >= limitM1);

  always_comb begin
    stb.capture  = faultNow;
    stb.clearCap = cfgRdEn && capValid;
    stb.ackHit   = iackActive && irqPend && (iackLevel == curLevel);
  end

  // Prescaled stall timer: microsecond ticks, then microsecond count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      usCnt   <= '0;
    end else if (!stalled || faultNow) begin
      tickCnt <= '0;
      usCnt   <= '0;
    end else if (tickLast) begin
      tickCnt <= '0;
      usCnt   <= usCnt + TMO_W'(1);
    end else begin
      tickCnt <= tickCnt + TICK_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capValid <= 1'b0;
      irqPend  <= 1'b0;
      dtackOut <= 1'b0;
    end else begin
      if (faultNow)          capValid <= 1'b1;
      else if (stb.clearCap) capValid <= 1'b0;

      if (faultNow)        irqPend <= 1'b1;
      else if (stb.ackHit) irqPend <= 1'b0;

      if (faultNow)       dtackOut <= 1'b1;
      else if (!asActive) dtackOut <= 1'b0;
    end
  end

endmodule

// File: rtl/busCatchData.sv
module busCatchData
  import busCatchPkg::*;
#(
  parameter int         TMO_W        = 8,
  parameter logic [7:0] RESET_VECTOR = 8'h0F
) (
  input  logic             clk,
  input  logic             rstN,
  input  catchStrobe_t     stb,
  input  logic             irqPend,
  input  logic             cfgWrEn,
  input  logic [31:0]      cfgWdata,
  input  logic [15:0]      addrHi,
  input  logic             addr32,
  input  logic [5:0]       amIn,
  input  logic [7:0]       xamIn,
  output logic [31:0]      cfgRdata,
  output logic [6:0]       irqOut,
  output logic             vecValid,
  output logic [7:0]       vecOut,
  output logic [TMO_W-1:0] tmoVal,
  output logic [2:0]       curLevel
);

  localparam int LEVELS = 7;

  logic [7:0] vector;
  logic [7:0] capAddr;
  logic [7:0] capXam;
  logic [5:0] capAm;
  logic [2:0] newLevel;
  logic       unusedWdata;

  assign unusedWdata = ^{cfgWdata[31:24], cfgWdata[0]};

  // Highest requested level wins; no bit set keeps the current level
  always_comb begin
    newLevel = curLevel;
    for (int i = 1; i <= LEVELS; i++) begin
      if (cfgWdata[i]) newLevel = 3'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLevel <= 3'd1;
      vector   <= RESET_VECTOR;
      tmoVal   <= '0;
    end else if (cfgWrEn) begin
      curLevel <= newLevel;
      vector   <= cfgWdata[15:8];
      tmoVal   <= cfgWdata[16 +: TMO_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAddr <= '0;
      capXam  <= '0;
      capAm   <= '0;
    end else if (stb.capture) begin
      capAddr <= addr32 ? addrHi[15:8] : addrHi[7:0];
      capXam  <= xamIn;
      capAm   <= amIn;
    end else if (stb.clearCap) begin
      capAddr <= '0;
      capXam  <= '0;
      capAm   <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecOut   <= '0;
    end else begin
      vecValid <= stb.ackHit;
      vecOut   <= stb.ackHit ? vector : 8'h00;
    end
  end

  assign cfgRdata = {8'h00, capAddr, capXam, 2'b00, capAm};

  for (genvar g = 0; g < LEVELS; g++) begin : gLevel
    assign irqOut[g] = irqPend && (curLevel == 3'(g + 1));
  end

endmodule

// File: rtl/busCatch.sv
module busCatch
  import busCatchPkg::*;
#(
  parameter int         CLK_PER_US   = 125,
  parameter int         DEFAULT_US   = 8,
  parameter int         TMO_W        = 8,
  parameter logic [7:0] RESET_VECTOR = 8'h0F
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        asActive,
  input  logic        dtackIn,
  input  logic [15:0] addrHi,
  input  logic        addr32,
  input  logic [5:0]  amIn,
  input  logic [7:0]  xamIn,
  output logic        dtackOut,
  output logic [6:0]  irqOut,
  input  logic        iackActive,
  input  logic [2:0]  iackLevel,
  output logic        vecValid,
  output logic [7:0]  vecOut,
  input  logic        cfgWrEn,
  input  logic        cfgRdEn,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata
);

  catchStrobe_t     stb;
  logic             irqPend;
  logic [TMO_W-1:0] tmoVal;
  logic [2:0]       curLevel;

  busCatchCtrl #(
    .CLK_PER_US(CLK_PER_US),
    .DEFAULT_US(DEFAULT_US),
    .TMO_W     (TMO_W)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .asActive  (asActive),
    .dtackIn   (dtackIn),
    .iackActive(iackActive),
    .iackLevel (iackLevel),
    .cfgRdEn   (cfgRdEn),
    .tmoVal    (tmoVal),
    .curLevel  (curLevel),
    .dtackOut  (dtackOut),
    .irqPend   (irqPend),
    .stb       (stb)
  );

  busCatchData #(
    .TMO_W       (TMO_W),
    .RESET_VECTOR(RESET_VECTOR)
  ) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .irqPend (irqPend),
    .cfgWrEn (cfgWrEn),
    .cfgWdata(cfgWdata),
    .addrHi  (addrHi),
    .addr32  (addr32),
    .amIn    (amIn),
    .xamIn   (xamIn),
    .cfgRdata(cfgRdata),
    .irqOut  (irqOut),
    .vecValid(vecValid),
    .vecOut  (vecOut),
    .tmoVal  (tmoVal),
    .curLevel(curLevel)
  );

endmodule

// File: rtl/busCatchChk.sv
module busCatchChk (
  input logic        clk,
  input logic        rstN,
  input logic        asActive,
  input logic        dtackOut,
  input logic [6:0]  irqOut,
  input logic        vecValid,
  input logic        cfgRdEn,
  input logic [31:0] cfgRdata
);

  AST_DTACK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dtackOut && asActive) |=> dtackOut);                         // R3
  AST_DTACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !asActive |=> !dtackOut);                                     // R3
  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqOut));                                            // R6
  AST_DTACK_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dtackOut) |-> (irqOut != 7'd0));                        // R6
  AST_VEC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);                                      // R7
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (irqOut == 7'd0));                               // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdEn && cfgRdata != 32'd0) |=> (cfgRdata == 32'd0));      // R5

endmodule

bind busCatch busCatchChk u_busCatchChk (
  .clk     (clk),
  .rstN    (rstN),
  .asActive(asActive),
  .dtackOut(dtackOut),
  .irqOut  (irqOut),
  .vecValid(vecValid),
  .cfgRdEn (cfgRdEn),
  .cfgRdata(cfgRdata)
);

// File: tb/test_busCatch.sv
module test_busCatch;

  localparam int CPU = 125;
  localparam int DEF = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        asActive = 1'b0;
  logic        dtackIn = 1'b0;
  logic [15:0] addrHi = '0;
  logic        addr32 = 1'b0;
  logic [5:0]  amIn = '0;
  logic [7:0]  xamIn = '0;
  logic        iackActive = 1'b0;
  logic [2:0]  iackLevel = '0;
  logic        cfgWrEn = 1'b0;
  logic        cfgRdEn = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic        dtackOut;
  logic [6:0]  irqOut;
  logic        vecValid;
  logic [7:0]  vecOut;
  logic [31:0] cfgRdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  busCatch i_busCatch (
    .clk(clk), .rstN(rstN), .asActive(asActive), .dtackIn(dtackIn),
    .addrHi(addrHi), .addr32(addr32), .amIn(amIn), .xamIn(xamIn),
    .dtackOut(dtackOut), .irqOut(irqOut), .iackActive(iackActive),
    .iackLevel(iackLevel), .vecValid(vecValid), .vecOut(vecOut),
    .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural reference, advanced on every rising edge
  int         mLevel, mStall;
  logic [7:0] mVec, mTmo, mVecOut;
  logic       mDtack, mPend, mValid, mVecValid;
  logic [31:0] mCap;

  always @(posedge clk) begin
    if (!rstN) begin
      mLevel = 1; mVec = 8'h0F; mTmo = 8'h00; mStall = 0;
      mDtack = 0; mPend = 0; mValid = 0; mCap = 0;
      mVecValid = 0; mVecOut = 0;
    end else begin
      int  lim;
      bit  fault;
      bit  ack;
      lim   = (mTmo == 0) ? DEF : int'(mTmo);
      fault = 0;
      ack   = iackActive && mPend && (int'(iackLevel) == mLevel);
      if (asActive && !dtackIn && !mPend && !mValid && !mDtack) begin
        mStall++;
        if (mStall >= lim * CPU) begin fault = 1; mStall = 0; end
      end else mStall = 0;
      if (cfgRdEn && mValid) begin mValid = 0; mCap = 0; end
      if (ack) mPend = 0;
      if (fault) begin
        mValid = 1; mPend = 1; mDtack = 1;
        mCap = {8'h00, (addr32 ? addrHi[15:8] : addrHi[7:0]), xamIn, 2'b00, amIn};
      end else if (!asActive) mDtack = 0;
      mVecValid = ack;
      mVecOut   = ack ? mVec : 8'h00;
      if (cfgWrEn) begin
        for (int i = 1; i <= 7; i++) if (cfgWdata[i]) mLevel = i;
        mVec = cfgWdata[15:8];
        mTmo = cfgWdata[23:16];
      end
    end
  end

  // Compare against the model away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R3 dtackOut vs model", 32'(dtackOut), 32'(mDtack));
      check("R6 irqOut vs model", 32'(irqOut), mPend ? 32'(1 << (mLevel - 1)) : 32'd0);
      check("R7 vecValid vs model", 32'(vecValid), 32'(mVecValid));
      check("R7 vecOut vs model", 32'(vecOut), 32'(mVecOut));
      check("R4 cfgRdata vs model", cfgRdata, mCap);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Stall until dtackOut appears or maxc edges pass; n counts edges
  task automatic stall(int maxc, output int n);
    asActive = 1'b1;
    n = 0;
    while (n < maxc) begin
      @(negedge clk);
      n++;
      if (dtackOut) break;
    end
  endtask

  task automatic releaseAs();
    asActive = 1'b0;
    @(negedge clk);
  endtask

  task automatic readCap();
    cfgRdEn = 1'b1;
    @(negedge clk);
    cfgRdEn = 1'b0;
  endtask

  task automatic ack(logic [2:0] lvl);
    iackActive = 1'b1; iackLevel = lvl;
    @(negedge clk);
    iackActive = 1'b0;
  endtask

  task automatic cfgWrite(logic [31:0] d);
    cfgWrEn = 1'b1; cfgWdata = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset dtackOut", 32'(dtackOut), 0);
    check("R1 reset irqOut", 32'(irqOut), 0);
    check("R1 reset vecValid", 32'(vecValid), 0);
    check("R1 reset cfgRdata", cfgRdata, 0);

    // Default timeout, 32-bit access
    addrHi = 16'hA55A; addr32 = 1'b1; amIn = 6'h0D; xamIn = 8'h3C;
    stall(5000, n);
    check("R2 default limit edges", 32'(n), DEF * CPU);
    check("R1 reset level 1 on irqOut", 32'(irqOut), 32'h01);
    repeat (4) @(negedge clk);
    check("R3 dtackOut held", 32'(dtackOut), 1);
    releaseAs();
    check("R3 dtackOut released", 32'(dtackOut), 0);
    check("R4 snapshot fields wide", cfgRdata, 32'h00A53C0D);

    // Wrong level ignored, right level answered
    ack(3'd4);
    check("R7 wrong level no vector", 32'(vecValid), 0);
    check("R7 wrong level irq kept", 32'(irqOut), 32'h01);
    ack(3'd1);
    check("R7 vector on match", 32'(vecOut), 32'h0F);
    check("R7 irq dropped", 32'(irqOut), 0);

    // Locked: acknowledged but unread
    addrHi = 16'h1234; amIn = 6'h09;
    stall(1200, n);
    check("R8 no termination while unread", 32'(dtackOut), 0);
    check("R8 snapshot kept", cfgRdata, 32'h00A53C0D);
    releaseAs();
    readCap();
    check("R5 snapshot cleared after read", cfgRdata, 0);

    // Configure: level 5 (bits 3 and 5 set), vector 77, timeout 3 us
    cfgWrite(32'h00037728);
    addr32 = 1'b0; addrHi = 16'h12C7; amIn = 6'h3D; xamIn = 8'h81;
    stall(5000, n);
    check("R9 re-armed after ack and read", 32'(dtackOut), 1);
    check("R10 timeout field edges", 32'(n), 3 * CPU);
    check("R6 level 5 request", 32'(irqOut), 32'h10);
    releaseAs();
    check("R4 snapshot fields narrow", cfgRdata, 32'h00C7813D);

    // Locked: read but not acknowledged
    readCap();
    stall(600, n);
    check("R8 no termination while pending", 32'(dtackOut), 0);
    releaseAs();
    cfgWrite(32'h00020000);
    check("R6 empty level byte keeps level", 32'(irqOut), 32'h10);
    ack(3'd5);
    check("R10 written vector", 32'(vecOut), 32'h00);

    // Restart of the count by a slave acknowledge pulse
    stall(100, n);
    dtackIn = 1'b1;
    @(negedge clk);
    dtackIn = 1'b0;
    stall(5000, n);
    check("R2 count restarted", 32'(n), 2 * CPU);
    releaseAs();
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule